// File: doc/BRIEF.md
# Multiplexed Parallel Register Port

This block lets an external microcontroller reach a bank of 128 byte-wide internal registers over one 8-bit bus that carries both addresses and data. A select input tells the block whether the byte on the bus is a command or a data byte, and a strobe input marks when that byte is valid. A command byte holds a 7-bit register address and a direction flag. Each data byte that follows either writes the selected register or asks for its contents, which the block then puts on the bus.

The host signals are asynchronous to the system clock, so select, strobe and bus pass through synchronisers before any decision is made. The moment at which a byte is taken is set by straps: the levels on bus bits 6:4 at reset release choose capture on the strobe rising edge, capture on the strobe falling edge, or capture while the strobe is high. Any other code leaves the port dormant. The bus pins are open-drain, so the block only reports which pins to pull low.

Top module: `hostBusPort`

## Requirements
- R1: While reset is asserted no bus pin is pulled low and no register write is issued.
- R2: A capture with select low takes bits 6:0 of the bus as the register address and bit 7 as direction (0 = write, 1 = read); the latched address cannot be read back.
- R3: A capture with select high after a write command issues exactly one single-cycle write pulse, carrying the latched address and the captured byte.
- R4: After a read command, while the synchronised strobe and select are both high, each bus pin whose register bit is 0 is pulled low and each pin whose bit is 1 is released; at all other times no pin is pulled low.
- R5: Strap code 010 on bus bits 6:4 at reset release makes the port capture on the strobe rising edge, taking the byte present at that edge.
- R6: Strap code 011 makes the port capture on the strobe falling edge, taking the byte present at that edge.
- R7: Strap code 000 makes the port capture while the strobe is high, once per high period however long the strobe stays high.
- R8: Strap codes other than 010, 011 and 000 disable the port: no writes and no bus drive until the next reset.
- R9: A data byte that arrives before any command byte since reset is ignored.
- R10: A data byte that follows a read command causes no write.
- R11: The latched address stays in force until the next command byte, so several data bytes in a row all write the same register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset; straps sampled on release |
| selIn | input | 1 | Byte select from host: 0 command, 1 data |
| strobeIn | input | 1 | Host strobe |
| busIn | input | 8 | Levels seen on the shared bus pins |
| busPullLow | output | 8 | Per-pin open-drain enable: 1 pulls the pin low |
| regAddr | output | 7 | Register file address |
| regWrData | output | 8 | Register file write data |
| regWrEn | output | 1 | Register file write pulse |
| regRdData | input | 8 | Register file read data for regAddr |

## Verification
A wrong latched address or direction flag surfaces on the very next data byte, either as a write pulse to the wrong register or as a wrong pattern of pulled-low pins during a read. A wrongly strapped capture mode shows within one transaction as a byte taken at the wrong strobe edge, as a missing write, or as extra writes during a long strobe. Sweeping every register in each live mode and reading each one back exposes an address or data error within a few host transactions of its cause.

// File: rtl/hbpPkg.sv
package hbpPkg;

  typedef enum logic [1:0] {
    MODE_OFF   = 2'd0,
    MODE_RISE  = 2'd1,
    MODE_FALL  = 2'd2,
    MODE_LEVEL = 2'd3
  } hbpMode_e;

  // control to datapath strobes
  typedef struct packed {
    logic capAddr;   // take the bus byte as a command
    logic capData;   // take the bus byte as data
    logic drive;     // strobe and select both high on a live port
  } hbpStrobes_t;

  function automatic hbpMode_e decodeStrap(input logic [2:0] code);
    case (code)
      3'b010:  return MODE_RISE;
      3'b011:  return MODE_FALL;
      3'b000:  return MODE_LEVEL;
      default: return MODE_OFF;
    endcase
  endfunction

endpackage

// File: rtl/hbpSync.sv
module hbpSync #(
  parameter int WIDTH  = 10,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [STAGES-1:0][WIDTH-1:0] chain;

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN)
          if (!rstN) chain[s] <= '0;
          else       chain[s] <= din;
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN)
          if (!rstN) chain[s] <= '0;
          else       chain[s] <= chain[s-1];
      end
    end
  endgenerate

  assign dout = chain[STAGES-1];

endmodule

// File: rtl/hbpCtrl.sv
module hbpCtrl
  import hbpPkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int STRAP_LO = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] busRaw,
  input  logic              selS,
  input  logic              stbS,
  output hbpStrobes_t       strb
);

  localparam int STRAP_HI = STRAP_LO + 2;

  hbpMode_e strapMode;
  logic     strapDone;
  logic     stbPrev;
  logic     levelDone;
  logic     portLive;
  logic     stbRise, stbFall, levelHit;
  logic     capture;

  // mode straps are taken on the first clock after reset release
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      strapMode <= MODE_OFF;
      strapDone <= 1'b0;
    end else if (!strapDone) begin
      strapMode <= decodeStrap(busRaw[STRAP_HI:STRAP_LO]);
      strapDone <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stbPrev <= 1'b0;
    else       stbPrev <= stbS;
  end

  assign portLive = strapDone && (strapMode != MODE_OFF);
  assign stbRise  = stbS && !stbPrev;
  assign stbFall  = !stbS && stbPrev;
  assign levelHit = stbS && stbPrev && !levelDone;

  always_comb begin
    case (strapMode)
      MODE_RISE:  capture = portLive && stbRise;
      MODE_FALL:  capture = portLive && stbFall;
      MODE_LEVEL: capture = portLive && levelHit;
      default:    capture = 1'b0;
    endcase
  end

  // one capture per high period in level mode
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       levelDone <= 1'b0;
    else if (!stbS)  levelDone <= 1'b0;
    else if (capture) levelDone <= 1'b1;
  end

  assign strb.capAddr = capture && !selS;
  assign strb.capData = capture && selS;
  assign strb.drive   = portLive && stbS && selS;

  p_mode_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    strapDone |=> $stable(strapMode));

  p_cap_single_r7: assert property (@(posedge clk) disable iff (!rstN)
    (strb.capAddr || strb.capData) |=> !(strb.capAddr || strb.capData));

  p_off_silent_r8: assert property (@(posedge clk) disable iff (!rstN)
    (strapDone && strapMode == MODE_OFF) |-> !(strb.capAddr || strb.capData || strb.drive));

  p_level_once_r7: assert property (@(posedge clk) disable iff (!rstN)
    (strapMode == MODE_LEVEL && levelDone && stbS) |-> !capture);

endmodule

// File: rtl/hbpDatapath.sv
module hbpDatapath
  import hbpPkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  hbpStrobes_t       strb,
  input  logic [DATA_W-1:0] busS,
  input  logic [DATA_W-1:0] regRdData,
  output logic [DATA_W-2:0] regAddr,
  output logic [DATA_W-1:0] regWrData,
  output logic              regWrEn,
  output logic [DATA_W-1:0] busPullLow
);

  localparam int ADDR_W  = DATA_W - 1;
  localparam int DIR_BIT = DATA_W - 1;

  logic [ADDR_W-1:0] addrReg;
  logic              rdFlag;
  logic              addrValid;
  logic              wrEnQ;
  logic [DATA_W-1:0] wrDataQ;
  logic              readLive;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrReg   <= '0;
      rdFlag    <= 1'b0;
      addrValid <= 1'b0;
    end else if (strb.capAddr) begin
      addrReg   <= busS[ADDR_W-1:0];
      rdFlag    <= busS[DIR_BIT];
      addrValid <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrEnQ   <= 1'b0;
      wrDataQ <= '0;
    end else begin
      wrEnQ <= strb.capData && addrValid && !rdFlag;
      if (strb.capData && addrValid && !rdFlag) wrDataQ <= busS;
    end
  end

  assign readLive   = strb.drive && addrValid && rdFlag;
  assign busPullLow = readLive ? ~regRdData : '0;
  assign regAddr    = addrReg;
  assign regWrData  = wrDataQ;
  assign regWrEn    = wrEnQ;

  p_wr_addr_valid_r9: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |-> addrValid);

  p_wr_not_read_r10: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |-> !rdFlag);

  p_drive_read_r4: assert property (@(posedge clk) disable iff (!rstN)
    (busPullLow != '0) |-> (rdFlag && addrValid && strb.drive));

  p_addr_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    !strb.capAddr |=> $stable(regAddr));

  p_wr_pulse_r3: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |=> !regWrEn);

endmodule

// File: rtl/hostBusPort.sv
module hostBusPort
  import hbpPkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int STRAP_LO    = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              selIn,
  input  logic              strobeIn,
  input  logic [DATA_W-1:0] busIn,
  output logic [DATA_W-1:0] busPullLow,
  output logic [DATA_W-2:0] regAddr,
  output logic [DATA_W-1:0] regWrData,
  output logic              regWrEn,
  input  logic [DATA_W-1:0] regRdData
);

  localparam int SYNC_W = DATA_W + 2;

  logic [SYNC_W-1:0] syncOut;
  logic              selS, stbS;
  logic [DATA_W-1:0] busS;
  hbpStrobes_t       strb;

  hbpSync #(.WIDTH(SYNC_W), .STAGES(SYNC_STAGES)) uSync (
    .clk  (clk),
    .rstN (rstN),
    .din  ({selIn, strobeIn, busIn}),
    .dout (syncOut)
  );

  assign selS = syncOut[SYNC_W-1];
  assign stbS = syncOut[SYNC_W-2];
  assign busS = syncOut[DATA_W-1:0];

  hbpCtrl #(.DATA_W(DATA_W), .STRAP_LO(STRAP_LO)) uCtrl (
    .clk    (clk),
    .rstN   (rstN),
    .busRaw (busIn),
    .selS   (selS),
    .stbS   (stbS),
    .strb   (strb)
  );

  hbpDatapath #(.DATA_W(DATA_W)) uData (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .busS       (busS),
    .regRdData  (regRdData),
    .regAddr    (regAddr),
    .regWrData  (regWrData),
    .regWrEn    (regWrEn),
    .busPullLow (busPullLow)
  );

endmodule

// File: tb/tb_hostBusPort.sv
module tb_hostBusPort;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       selIn = 1'b0;
  logic       strobeIn = 1'b0;
  logic [7:0] busIn = 8'h00;
  logic [7:0] busPullLow;
  logic [6:0] regAddr;
  logic [7:0] regWrData;
  logic       regWrEn;
  logic [7:0] regRdData;

  logic [7:0] mem [128];
  int         wrCount = 0;
  logic [6:0] lastAddr = '0;
  logic [7:0] lastData = '0;
  int         nChk = 0;
  int         nBad = 0;
  bit         finished = 1'b0;

  always #4 clk = ~clk;

  hostBusPort dut (
    .clk(clk), .rstN(rstN), .selIn(selIn), .strobeIn(strobeIn), .busIn(busIn),
    .busPullLow(busPullLow), .regAddr(regAddr), .regWrData(regWrData),
    .regWrEn(regWrEn), .regRdData(regRdData)
  );

  assign regRdData = mem[regAddr];

  always @(posedge clk) begin
    if (regWrEn) begin
      mem[regAddr] <= regWrData;
      wrCount  <= wrCount + 1;
      lastAddr <= regAddr;
      lastData <= regWrData;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChk++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitN(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic doReset(input logic [2:0] strap);
    @(negedge clk);
    rstN = 1'b0; selIn = 1'b0; strobeIn = 1'b0;
    busIn = {1'b0, strap, 4'h0};
    waitN(2);
    strobeIn = 1'b1; selIn = 1'b1;
    waitN(3);
    chk(busPullLow == 8'h00, "R1 pull during reset", busPullLow, 0);
    chk(regWrEn == 1'b0, "R1 write during reset", regWrEn, 0);
    strobeIn = 1'b0; selIn = 1'b0;
    waitN(1);
    rstN = 1'b1;
    waitN(2);
    busIn = 8'h00;
    waitN(4);
  endtask

  task automatic phase(input logic sel, input logic [7:0] b, input int high);
    selIn = sel; busIn = b;
    waitN(4);
    strobeIn = 1'b1;
    waitN(high);
    strobeIn = 1'b0;
    waitN(6);
  endtask

  task automatic readReg(input logic [6:0] a, output logic [7:0] v, output logic [7:0] after);
    phase(1'b0, {1'b1, a}, 5);
    selIn = 1'b1; busIn = 8'hFF;
    waitN(4);
    strobeIn = 1'b1;
    waitN(6);
    v = ~busPullLow;
    strobeIn = 1'b0;
    waitN(6);
    after = busPullLow;
  endtask

  function automatic logic [7:0] pat(input int a, input int m);
    return 8'((a * 37 + m * 11 + 5) & 8'hFF);
  endfunction

  initial begin
    logic [2:0] straps [3];
    logic [7:0] v, after;
    int c0;
    straps[0] = 3'b010; straps[1] = 3'b011; straps[2] = 3'b000;
    for (int i = 0; i < 128; i++) mem[i] = 8'h00;

    for (int m = 0; m < 3; m++) begin
      doReset(straps[m]);
      // R9: data before any command byte
      c0 = wrCount;
      phase(1'b1, 8'h5A, 5);
      chk(wrCount == c0, "R9 data without address", wrCount - c0, 0);
      // sweep writes
      for (int a = 0; a < 128; a++) begin
        c0 = wrCount;
        phase(1'b0, {1'b0, 7'(a)}, 5);
        phase(1'b1, pat(a, m), 5);
        chk(wrCount == c0 + 1, "R3 one write pulse", wrCount - c0, 1);
        chk(lastAddr == 7'(a), "R2 latched address", lastAddr, a);
        chk(lastData == pat(a, m), "R3 write data", lastData, pat(a, m));
      end
      // sweep reads
      for (int a = 0; a < 128; a++) begin
        readReg(7'(a), v, after);
        chk(v == pat(a, m), "R4 read drive", v, pat(a, m));
        chk(after == 8'h00, "R4 release after strobe", after, 0);
      end
      // R10: data after read command writes nothing
      c0 = wrCount;
      phase(1'b0, 8'h80 | 8'd9, 5);
      phase(1'b1, 8'hC3, 5);
      chk(wrCount == c0, "R10 data after read command", wrCount - c0, 0);
      // R11: address persists across data bytes
      c0 = wrCount;
      phase(1'b0, 8'd20, 5);
      phase(1'b1, 8'h11, 5);
      phase(1'b1, 8'h22, 5);
      chk(wrCount == c0 + 2, "R11 two writes", wrCount - c0, 2);
      chk(lastAddr == 7'd20 && lastData == 8'h22, "R11 same address", {lastAddr, lastData}, {7'd20, 8'h22});
      // long strobe: one write only (R7 in level mode)
      c0 = wrCount;
      phase(1'b1, 8'h44, 40);
      chk(wrCount == c0 + 1, "R7 long strobe single write", wrCount - c0, 1);
      // bus changes while strobe high: R5 takes first, R6 takes second
      selIn = 1'b1; busIn = 8'hA1;
      waitN(4);
      strobeIn = 1'b1;
      waitN(6);
      busIn = 8'hB2;
      waitN(6);
      strobeIn = 1'b0;
      waitN(6);
      if (m == 0) chk(lastData == 8'hA1, "R5 rising capture", lastData, 8'hA1);
      else if (m == 1) chk(lastData == 8'hB2, "R6 falling capture", lastData, 8'hB2);
      else chk(lastData == 8'hA1, "R7 level capture", lastData, 8'hA1);
    end

    // R8: disabled straps
    for (int k = 0; k < 2; k++) begin
      doReset(k == 0 ? 3'b100 : 3'b001);
      c0 = wrCount;
      phase(1'b0, 8'd3, 5);
      phase(1'b1, 8'h77, 5);
      chk(wrCount == c0, "R8 disabled no write", wrCount - c0, 0);
      readReg(7'd3, v, after);
      chk(v == 8'hFF, "R8 disabled no drive", ~v, 0);
    end

    $display("test done: total=%0d bad=%0d", nChk, nBad);
    finished = 1'b1;
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nChk++;
      nBad++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("test done: total=%0d bad=%0d", nChk, nBad);
      $finish;
    end
  end

endmodule